// File: doc/BRIEF.md
# Floating-Point Control Register with Exception Trap Routing

This block holds the 64-bit control word that steers a floating-point unit, and it decides what happens to each exception event that the arithmetic datapath reports. Software writes the control word through a write strobe and a data bus, and the word is always visible on a read bus. Reserved bit positions and fields that the build leaves out are never stored, so they always read as zero. The mode bits (alternative half-precision format, default-NaN, flush-to-zero for single and double, flush-to-zero for half precision, and the rounding mode) are brought out as separate signals for the datapath.

The datapath reports up to six exceptions per cycle: invalid operation, divide-by-zero, overflow, underflow, inexact and input denormal. For each exception the matching enable bit in the control word chooses the outcome. If the enable is clear, the exception sets a sticky flag in a small status register. If the enable is set, the block raises a trap request with a per-exception cause vector and leaves the flag alone. Sticky flags are cleared only by a status write. The vector-length and stride fields exist only so that software can save and restore them. They change nothing else.

Top module: `fpctl_trap_router`

## Requirements
- R1: Control-word bits 63:27, 14:13 and 7:0 always read as zero, whatever was written.
- R2: Bits 26 (alternative half format), 25 (default NaN), 24 (flush-to-zero) and 23:22 are stored on a write and read back on `ctl_rdata` from the cycle after the write. Bits 26, 25 and 24 are driven on `alt_half`, `dflt_nan` and `flush_zero`.
- R3: `rnd_mode` equals bits 23:22, coded 00 nearest, 01 toward plus infinity, 10 toward minus infinity, 11 toward zero.
- R4: With `KEEP_VEC_FIELDS`=1, bits 21:20 and 18:16 are stored and read back with no effect on any other output. With `KEEP_VEC_FIELDS`=0 they read as zero.
- R5: Bit 19 (half-precision flush) is stored and drives `flush_half` only when `HAS_HALF`=1. Otherwise it reads as zero.
- R6: Trap enables sit at bit 8 (invalid), 9 (divide-by-zero), 10 (overflow), 11 (underflow), 12 (inexact) and 15 (input denormal). An enable whose bit is clear in `EXC_SUPPORT` reads as zero and ignores writes, so that exception is always untrapped.
- R7: An event whose enable is 0 sets its sticky flag in the next cycle and raises no trap. Exception index i is `exc_evt[i]`, `sts_rdata[i]` and `trap_cause[i]`, with 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact and 5 input denormal.
- R8: An event whose enable is 1 drives `trap_req` and its `trap_cause` bit high for exactly the next cycle and leaves its sticky flag unchanged.
- R9: A sticky flag stays set until a status write (`sts_we`) loads `sts_wdata`. If an event and a status write that clears the flag arrive in the same cycle, the flag ends up set.
- R10: When `evt_half` and `flush_half` are both 1, an input-denormal event is discarded: no flag, no trap.
- R11: After reset the control word equals `RST_CTRL` with unimplemented and reserved bits forced to zero. Sticky flags and trap outputs reset to zero.
- R12: Events that fire in the same cycle are each routed on their own enable, and `trap_req` is the OR of all trapped events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control-word write strobe |
| ctl_wdata | input | 64 | Control-word write data |
| ctl_rdata | output | 64 | Current control word |
| sts_we | input | 1 | Sticky-flag write strobe |
| sts_wdata | input | 6 | New sticky-flag values |
| sts_rdata | output | 6 | Current sticky flags |
| exc_evt | input | 6 | Exception event pulses from the datapath |
| evt_half | input | 1 | The events this cycle come from a half-precision operation |
| trap_req | output | 1 | A trapped exception occurred in the previous cycle |
| trap_cause | output | 6 | Which exceptions were trapped |
| rnd_mode | output | 2 | Rounding mode for the datapath |
| alt_half | output | 1 | Alternative half-precision format selected |
| dflt_nan | output | 1 | Default-NaN mode |
| flush_zero | output | 1 | Flush-to-zero for single and double precision |
| flush_half | output | 1 | Flush-to-zero for half precision |

## Verification
The hardest situation to reach is a collision: an event fires in the same cycle that software rewrites the status register or the enables. Two resolutions must then hold together. The old enable value governs the event. The flag set wins over a clear in the same cycle. Random stimulus drives control writes, status writes, half-precision markers and multi-bit event vectors on the same cycle at high rates, so these overlaps occur often. Directed cases then pin down the exact clear-versus-set collision and the suppression of a flushed half-precision denormal.

// File: rtl/fpctl_pkg.sv
package fpctl_pkg;
  localparam int CTL_W = 64;
  localparam int NEXC  = 6;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_POS_INF = 2'b01,
    RND_NEG_INF = 2'b10,
    RND_ZERO    = 2'b11
  } rnd_mode_e;

  localparam int EXC_INV = 0;
  localparam int EXC_DZ  = 1;
  localparam int EXC_OVF = 2;
  localparam int EXC_UNF = 3;
  localparam int EXC_INX = 4;
  localparam int EXC_IDN = 5;

  localparam int POS_ALT  = 26;
  localparam int POS_DN   = 25;
  localparam int POS_FZ   = 24;
  localparam int POS_RM   = 22;
  localparam int POS_FZH  = 19;

  function automatic int en_pos(input int idx);
    case (idx)
      EXC_INV: return 8;
      EXC_DZ:  return 9;
      EXC_OVF: return 10;
      EXC_UNF: return 11;
      EXC_INX: return 12;
      default: return 15;
    endcase
  endfunction

  function automatic logic [CTL_W-1:0] write_mask(input bit has_half,
                                                  input bit keep_vec,
                                                  input logic [NEXC-1:0] sup);
    logic [CTL_W-1:0] m;
    m = '0;
    m[26:22] = '1;
    if (keep_vec) begin
      m[21:20] = '1;
      m[18:16] = '1;
    end
    if (has_half) m[POS_FZH] = 1'b1;
    for (int i = 0; i < NEXC; i++)
      if (sup[i]) m[en_pos(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fpctl_ctrl_reg.sv
module fpctl_ctrl_reg
  import fpctl_pkg::*;
#(
  parameter logic [CTL_W-1:0] RST_VAL = '0,
  parameter logic [CTL_W-1:0] MASK    = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] q
);
  localparam logic [CTL_W-1:0] RST_MASKED = RST_VAL & MASK;

  always_ff @(posedge clk) begin
    if (rst)     q <= RST_MASKED;
    else if (we) q <= wdata & MASK;
  end

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> (q == ($past(wdata) & MASK)));

  assert_hold_without_write_R1: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/fpctl_mode_decode.sv
module fpctl_mode_decode
  import fpctl_pkg::*;
(
  input  logic            alt_bit,
  input  logic            dn_bit,
  input  logic            fz_bit,
  input  logic [1:0]      rm_bits,
  input  logic            fzh_bit,
  input  logic [NEXC-1:0] exc_evt,
  input  logic            evt_half,
  output rnd_mode_e       rnd_mode,
  output logic            alt_half,
  output logic            dflt_nan,
  output logic            flush_zero,
  output logic            flush_half,
  output logic [NEXC-1:0] evt_eff
);
  always_comb begin
    rnd_mode   = rnd_mode_e'(rm_bits);
    alt_half   = alt_bit;
    dflt_nan   = dn_bit;
    flush_zero = fz_bit;
    flush_half = fzh_bit;
    evt_eff    = exc_evt;
    if (evt_half && fzh_bit) evt_eff[EXC_IDN] = 1'b0;
  end
endmodule

// File: rtl/fpctl_exc_route.sv
module fpctl_exc_route
  import fpctl_pkg::*;
#(
  parameter int N = NEXC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_eff,
  input  logic [N-1:0] trap_en,
  input  logic         sts_we,
  input  logic [N-1:0] sts_wdata,
  output logic [N-1:0] flags,
  output logic         trap_req,
  output logic [N-1:0] trap_cause
);
  logic [N-1:0] trapped;

  for (genvar i = 0; i < N; i++) begin : g_exc
    assign trapped[i] = evt_eff[i] & trap_en[i];

    always_ff @(posedge clk) begin
      if (rst)
        flags[i] <= 1'b0;
      else if (evt_eff[i] && !trap_en[i])
        flags[i] <= 1'b1;
      else if (sts_we)
        flags[i] <= sts_wdata[i];
    end

    assert_untrapped_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
      (evt_eff[i] && !trap_en[i]) |=> flags[i]);

    assert_trapped_keeps_flag_R8: assert property (@(posedge clk) disable iff (rst)
      (evt_eff[i] && trap_en[i] && !sts_we) |=> $stable(flags[i]));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !sts_we) |=> flags[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req   <= 1'b0;
      trap_cause <= '0;
    end else begin
      trap_req   <= |trapped;
      trap_cause <= trapped;
    end
  end

  assert_trap_or_R12: assert property (@(posedge clk) disable iff (rst)
    (|(evt_eff & trap_en)) |=> trap_req);

  assert_trap_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (evt_eff == '0) |=> (!trap_req && trap_cause == '0));
endmodule

// File: rtl/fpctl_trap_router.sv
module fpctl_trap_router
  import fpctl_pkg::*;
#(
  parameter logic [63:0] RST_CTRL        = 64'hFFFF_0000_0040_0000,
  parameter bit          HAS_HALF        = 1'b1,
  parameter bit          KEEP_VEC_FIELDS = 1'b1,
  parameter logic [5:0]  EXC_SUPPORT     = 6'b01_1111
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_we,
  input  logic [63:0] ctl_wdata,
  output logic [63:0] ctl_rdata,
  input  logic        sts_we,
  input  logic [5:0]  sts_wdata,
  output logic [5:0]  sts_rdata,
  input  logic [5:0]  exc_evt,
  input  logic        evt_half,
  output logic        trap_req,
  output logic [5:0]  trap_cause,
  output logic [1:0]  rnd_mode,
  output logic        alt_half,
  output logic        dflt_nan,
  output logic        flush_zero,
  output logic        flush_half
);
  localparam logic [CTL_W-1:0] WMASK = write_mask(HAS_HALF, KEEP_VEC_FIELDS, EXC_SUPPORT);

  logic [CTL_W-1:0] ctl_q;
  logic [NEXC-1:0]  trap_en;
  logic [NEXC-1:0]  evt_eff;
  rnd_mode_e        rm_dec;

  fpctl_ctrl_reg #(.RST_VAL(RST_CTRL), .MASK(WMASK)) u_reg (
    .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata), .q(ctl_q)
  );

  always_comb
    for (int i = 0; i < NEXC; i++) trap_en[i] = ctl_q[en_pos(i)];

  fpctl_mode_decode u_dec (
    .alt_bit(ctl_q[POS_ALT]), .dn_bit(ctl_q[POS_DN]), .fz_bit(ctl_q[POS_FZ]),
    .rm_bits(ctl_q[POS_RM+1:POS_RM]), .fzh_bit(ctl_q[POS_FZH]),
    .exc_evt(exc_evt), .evt_half(evt_half),
    .rnd_mode(rm_dec), .alt_half(alt_half), .dflt_nan(dflt_nan),
    .flush_zero(flush_zero), .flush_half(flush_half), .evt_eff(evt_eff)
  );

  fpctl_exc_route #(.N(NEXC)) u_route (
    .clk(clk), .rst(rst), .evt_eff(evt_eff), .trap_en(trap_en),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .flags(sts_rdata),
    .trap_req(trap_req), .trap_cause(trap_cause)
  );

  assign ctl_rdata = ctl_q;
  assign rnd_mode  = rm_dec;

  assert_flushed_half_silent_R10: assert property (@(posedge clk) disable iff (rst)
    (exc_evt[EXC_IDN] && evt_half && flush_half && !sts_we && !sts_rdata[EXC_IDN])
      |=> (!sts_rdata[EXC_IDN] && !trap_cause[EXC_IDN]));

  assert_unsupported_untrapped_R6: assert property (@(posedge clk) disable iff (rst)
    (exc_evt[EXC_IDN] && !evt_half && !EXC_SUPPORT[EXC_IDN]) |=> sts_rdata[EXC_IDN]);

  assert_vec_fields_inert_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && (ctl_wdata[26:22] == ctl_q[26:22]) && (ctl_wdata[19] == ctl_q[19]))
      |=> ($stable(rnd_mode) && $stable(alt_half) && $stable(flush_zero) && $stable(dflt_nan)));
endmodule

// File: tb/fpctl_trap_router_test.sv
module fpctl_trap_router_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic        ctl_we;
  logic [63:0] ctl_wdata, ctl_rdata;
  logic        sts_we;
  logic [5:0]  sts_wdata, sts_rdata;
  logic [5:0]  exc_evt;
  logic        evt_half;
  logic        trap_req;
  logic [5:0]  trap_cause;
  logic [1:0]  rnd_mode;
  logic        alt_half, dflt_nan, flush_zero, flush_half;

  logic [63:0] m_rdata;
  logic [5:0]  m_sts, m_cause;
  logic        m_req, m_alt, m_dn, m_fz, m_fzh;
  logic [1:0]  m_rm;

  fpctl_trap_router uut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata),
    .exc_evt(exc_evt), .evt_half(evt_half), .trap_req(trap_req), .trap_cause(trap_cause),
    .rnd_mode(rnd_mode), .alt_half(alt_half), .dflt_nan(dflt_nan),
    .flush_zero(flush_zero), .flush_half(flush_half)
  );

  fpctl_trap_router #(.HAS_HALF(1'b0), .KEEP_VEC_FIELDS(1'b0), .EXC_SUPPORT(6'h3F)) uut_min (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(m_rdata),
    .sts_we(1'b0), .sts_wdata(6'h0), .sts_rdata(m_sts),
    .exc_evt(6'h0), .evt_half(1'b0), .trap_req(m_req), .trap_cause(m_cause),
    .rnd_mode(m_rm), .alt_half(m_alt), .dflt_nan(m_dn),
    .flush_zero(m_fz), .flush_half(m_fzh)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  localparam logic [63:0] MASK_FULL = 64'h0000_0000_07FF_1F00;
  localparam logic [63:0] MASK_MIN  = 64'h0000_0000_07C0_9F00;

  logic [63:0] e_ctl;
  logic [5:0]  e_sts, e_cause;

  function automatic logic [5:0] enables(input logic [63:0] c);
    return {c[15], c[12], c[11], c[10], c[9], c[8]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk(ctl_rdata == e_ctl, "R1/R2 ctl_rdata", ctl_rdata, e_ctl);
    chk(sts_rdata == e_sts, "R7/R9 sts_rdata", {58'h0, sts_rdata}, {58'h0, e_sts});
    chk(trap_cause == e_cause, "R8/R12 trap_cause", {58'h0, trap_cause}, {58'h0, e_cause});
    chk(trap_req == (|e_cause), "R12 trap_req", {63'h0, trap_req}, {63'h0, |e_cause});
    chk(rnd_mode == e_ctl[23:22], "R3 rnd_mode", {62'h0, rnd_mode}, {62'h0, e_ctl[23:22]});
    chk({alt_half, dflt_nan, flush_zero, flush_half} == {e_ctl[26:24], e_ctl[19]},
        "R2/R5 mode bits", {60'h0, alt_half, dflt_nan, flush_zero, flush_half},
        {60'h0, e_ctl[26:24], e_ctl[19]});
  endtask

  task automatic step(input bit cwe, input logic [63:0] cwd, input bit swe,
                      input logic [5:0] swd, input logic [5:0] ev, input bit hf);
    logic [5:0] eff, en;
    ctl_we = cwe; ctl_wdata = cwd; sts_we = swe; sts_wdata = swd;
    exc_evt = ev; evt_half = hf;
    eff = ev;
    if (hf && e_ctl[19]) eff[5] = 1'b0;
    en = enables(e_ctl);
    @(posedge clk); #1;
    e_cause = eff & en;
    e_sts   = (swe ? swd : e_sts) | (eff & ~en);
    if (cwe) e_ctl = cwd & MASK_FULL;
    ctl_we = 0; sts_we = 0; exc_evt = 0; evt_half = 0;
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1; ctl_we = 0; ctl_wdata = 0; sts_we = 0; sts_wdata = 0; exc_evt = 0; evt_half = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    e_ctl = 64'h0000_0000_0040_0000; e_sts = 0; e_cause = 0;
    // R11: reset value masked, flags and trap cleared
    chk(ctl_rdata == 64'h0000_0000_0040_0000, "R11 reset ctl", ctl_rdata, 64'h0040_0000);
    check_all();

    // R1 R4 R5 R6: all ones written, only implemented bits stick
    step(1, '1, 0, 0, 0, 0);
    chk(ctl_rdata == MASK_FULL, "R1 R6 all-ones readback", ctl_rdata, MASK_FULL);
    chk(m_rdata == MASK_MIN, "R4 R5 minimal build readback", m_rdata, MASK_MIN);
    chk(m_fzh == 1'b0, "R5 no half flush in minimal build", {63'h0, m_fzh}, 64'h0);

    // R3: each rounding code
    for (int r = 0; r < 4; r++) begin
      step(1, 64'(r) << 22, 0, 0, 0, 0);
      chk(rnd_mode == 2'(r), "R3 rounding code", {62'h0, rnd_mode}, 64'(r));
    end

    // R4: vector fields change, nothing else does
    step(1, 64'h0037_0000, 0, 0, 0, 0);
    chk(ctl_rdata == 64'h0037_0000 && rnd_mode == 0 && !flush_half, "R4 vector fields inert",
        ctl_rdata, 64'h0037_0000);

    // R7: untrapped events set flags, no trap
    step(1, 64'h0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 6'b00_0101, 0);
    chk(sts_rdata == 6'b00_0101 && !trap_req, "R7 untrapped", {58'h0, sts_rdata}, 64'h5);

    // R8 R12: trap on overflow+inexact, others flag
    step(1, 64'h0000_1400, 1, 0, 0, 0);
    step(0, 0, 0, 0, 6'b11_1111, 0);
    chk(trap_cause == 6'b01_0100 && trap_req, "R8 R12 trap cause", {58'h0, trap_cause}, 64'h14);
    chk(sts_rdata == 6'b10_1011, "R8 flags untouched when trapped", {58'h0, sts_rdata}, 64'h2B);
    step(0, 0, 0, 0, 0, 0);
    chk(!trap_req, "R8 one-cycle trap pulse", {63'h0, trap_req}, 64'h0);

    // R6: unsupported input-denormal enable written 1 still untrapped
    step(1, 64'h0000_8000, 1, 0, 0, 0);
    step(0, 0, 0, 0, 6'b10_0000, 0);
    chk(sts_rdata[5] && !trap_req, "R6 unsupported always untrapped", {58'h0, sts_rdata}, 64'h20);

    // R9: set wins over same-cycle clear; hold otherwise
    step(0, 0, 1, 0, 6'b00_0010, 0);
    chk(sts_rdata == 6'b00_0010, "R9 set beats clear", {58'h0, sts_rdata}, 64'h2);
    repeat (3) step(0, 0, 0, 0, 0, 0);
    chk(sts_rdata == 6'b00_0010, "R9 sticky hold", {58'h0, sts_rdata}, 64'h2);

    // R10: half-precision denormal suppressed under half flush
    step(1, 64'h0008_0000, 1, 0, 0, 0);
    step(0, 0, 0, 0, 6'b10_0000, 1);
    chk(sts_rdata == 0, "R10 flushed half denormal silent", {58'h0, sts_rdata}, 64'h0);
    step(0, 0, 0, 0, 6'b10_0000, 0);
    chk(sts_rdata == 6'b10_0000, "R10 non-half denormal flagged", {58'h0, sts_rdata}, 64'h20);

    // Random mix (R2 R7 R8 R9 R10 R12 checked every step)
    for (int k = 0; k < 600; k++) begin
      logic [63:0] w;
      w = {$urandom, $urandom};
      step(($urandom % 4) == 0, w, ($urandom % 5) == 0, 6'($urandom),
           6'($urandom) & 6'($urandom), $urandom % 2);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule